// File: doc/BRIEF.md
# MDIO Management Master with Command Register

This block lets a host reach the management registers of an external PHY through one 32-bit command word. Software writes the word with an operation code, a PHY address, a register address and, for writes, sixteen data bits. The block then produces a management clock and shifts a serial frame onto the data line. The frame has a long run of ones, a start pattern, the operation, both addresses, a two-bit turnaround and the data. For a write the master drives the line for the whole frame. For a read it releases the line from the turnaround onward and collects the sixteen bits that the PHY returns.

Completion is signalled through the same word. The ready flag drops when a command is accepted and rises again when the frame is over. For a read, the data field then holds the bits that came back. If the interrupt-enable flag was set in the command, a level interrupt rises at the end and stays high until software writes the word again. The management clock runs at the system clock divided by twice the `HALF_PERIOD` parameter. It is active only while a frame is in progress.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the register reads 0x1000_0000 (only the ready flag, bit 28, set), `irq` is 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A frame holds exactly 64 rising `mdc` edges spaced 2*HALF_PERIOD system clocks apart. Ready returns 128*HALF_PERIOD clocks after the edge that accepted the command, and `mdc` is low whenever ready is 1.
- R3: A write command (bits 27:26 = 01) sends, MSB first and sampled at rising `mdc`: 32 ones, then 01, then 01, then PHY address (bits 25:21), then register address (bits 20:16), then 10, then data bits 15:0. `mdio_oe` is 1 for all 64 bit times.
- R4: `mdio_o` and `mdio_oe` never change on a rising edge of `mdc`.
- R5: A read command (bits 27:26 = 10) drives the first 46 bit times: 32 ones, 01, 10, PHY address and register address. It then holds `mdio_oe` at 0 for the last 18 bit times.
- R6: During a read, the 16 bits present on `mdio_i` at rising `mdc` in bit times 48 to 63 are stored MSB first into register bits 15:0.
- R7: An accepted command clears ready (bit 28) and sets it again at the end. The stored interrupt enable, opcode and addresses read back unchanged. Bits 31:30 always read 0, and the value written to bit 28 has no effect.
- R8: With interrupt enable (bit 29) set, `irq` rises together with ready and stays high until the next register write. With it clear, `irq` stays 0.
- R9: A register write while ready is 0 is ignored. The register contents and the frame in progress are unchanged.
- R10: Opcodes 00 and 11 start no frame: `mdc` stays low and `irq` stays 0, and ready reads 1 again on the second cycle after the write.
- R11: Whenever no frame is running, `mdio_oe` is 0, so the line is left to its pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Value written to the command register |
| rd_data | output | 32 | Current command register contents |
| irq | output | 1 | Level completion interrupt |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Drive enable for `mdio_o`; 0 releases the line |
| mdio_i | input | 1 | Serial data seen on the line |

## Verification
Writes are sent with data of all ones, all zeros and an alternating pattern, each with a different address pair. A swapped field, a wrong bit order or an off-by-one bit position then shows up as a mismatch in the 64 bits captured at rising `mdc`. Reads use two different return values, one of them asymmetric, so a reversed or shifted capture is visible. They also use the drive-enable profile to tell a master that releases at the turnaround from one that releases late. A command issued mid-frame, the two reserved opcodes, and commands with and without interrupt enable separate the accept, ignore and completion paths of the register handshake.

// File: rtl/mdio_pkg.sv
// Package: shared types for the management master.
// Assumes: frame payload is the 32 bits after the preamble.
package mdio_pkg;

    typedef enum logic [1:0] {
        OP_RSV_LO = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_RSV_HI = 2'b11
    } mdio_op_e;

    localparam int PAYLOAD_BITS = 32;
    localparam int HDR_BITS     = 14;   // start, opcode, two addresses
    localparam int TA_BITS      = 2;

endpackage

// File: rtl/mdc_divider.sv
// Module: mdc_divider
// Produces the management clock from the system clock while enabled.
// Assumes: HALF_PERIOD >= 2; the clock is held low and the phase counter is
// cleared whenever en is low, so every frame starts from the same phase.
module mdc_divider #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] WRAP_AT = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] phase_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap      = (phase_q == WRAP_AT);
    assign rise_tick = en && wrap && !mdc_q;
    assign fall_tick = en && wrap && mdc_q;
    assign mdc       = mdc_q;

    // Purpose: count half periods and toggle the clock at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= '0;
            mdc_q   <= 1'b0;
        end else if (wrap) begin
            phase_q <= '0;
            mdc_q   <= ~mdc_q;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    a_r2_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> !fall_tick);

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: mdio_frame_seq
// Walks one management frame bit by bit: preamble, then the 32-bit payload.
// Advances on the falling clock tick and samples read data on the rising tick.
// Assumes: command fields stay stable while active (the register holds them).
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata
);
    localparam int TOTAL = PRE_LEN + PAYLOAD_BITS;
    localparam int IW    = $clog2(TOTAL + 1);
    localparam logic [IW-1:0] LAST_W = IW'(TOTAL - 1);
    localparam logic [IW-1:0] PRE_W  = IW'(PRE_LEN);
    localparam logic [IW-1:0] TA_W   = IW'(PRE_LEN + HDR_BITS);
    localparam logic [IW-1:0] DAT_W  = IW'(PRE_LEN + HDR_BITS + TA_BITS);

    logic          active_q;
    logic [IW-1:0] idx_q;
    logic [15:0]   shift_q;
    logic [31:0]   payload;
    logic [IW-1:0] off;
    logic          is_read;
    logic          last_bit;

    assign is_read  = (op == OP_READ);
    assign last_bit = (idx_q == LAST_W);
    assign payload  = {2'b01, op, phy_addr, reg_addr, 2'b10, wdata};
    assign off      = idx_q - PRE_W;
    assign active   = active_q;
    assign done     = active_q && fall_tick && last_bit;
    assign rdata    = shift_q;

    // Purpose: track the current bit time of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q && fall_tick) begin
            if (last_bit) active_q <= 1'b0;
            else          idx_q    <= idx_q + 1'b1;
        end
    end

    // Purpose: collect returned data bits MSB first on rising clock ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (active_q && rise_tick && is_read && idx_q >= DAT_W) begin
            shift_q <= {shift_q[14:0], mdio_i};
        end
    end

    // Purpose: select the bit to drive and whether to drive at all.
    always_comb begin
        mdio_oe = active_q && !(is_read && idx_q >= TA_W);
        if (!active_q || idx_q < PRE_W) mdio_o = 1'b1;
        else                            mdio_o = payload[~off[4:0]];
    end

    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !mdio_oe);

    a_r6_capture_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !is_read) |=> $stable(shift_q));

endmodule

// File: rtl/mdio_cmd_reg.sv
// Module: mdio_cmd_reg
// Holds the 32-bit command/status word and runs the ready/interrupt handshake.
// Assumes: writes are accepted only while ready is set; reserved opcodes are
// stored but complete on the next cycle without a frame.
module mdio_cmd_reg
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        done,
    input  logic [15:0] rdata,
    output logic        start,
    output mdio_op_e    op,
    output logic [4:0]  phy_addr,
    output logic [4:0]  reg_addr,
    output logic [15:0] data,
    output logic [31:0] rd_data,
    output logic        irq
);
    logic        ie_q, ready_q, noop_q, irq_q;
    mdio_op_e    op_q;
    logic [4:0]  phy_q, ra_q;
    logic [15:0] dat_q;
    logic        accept;
    logic        op_valid;
    mdio_op_e    wr_op;

    assign wr_op    = mdio_op_e'(wr_data[27:26]);
    assign op_valid = (wr_op == OP_WRITE) || (wr_op == OP_READ);
    assign accept   = wr_en && ready_q;
    assign start    = accept && op_valid;

    assign op       = op_q;
    assign phy_addr = phy_q;
    assign reg_addr = ra_q;
    assign data     = dat_q;
    assign irq      = irq_q;
    assign rd_data  = {2'b00, ie_q, ready_q, op_q, phy_q, ra_q, dat_q};

    // Purpose: load commands, complete them and raise the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            ready_q <= 1'b1;
            noop_q  <= 1'b0;
            irq_q   <= 1'b0;
            op_q    <= OP_RSV_LO;
            phy_q   <= '0;
            ra_q    <= '0;
            dat_q   <= '0;
        end else if (accept) begin
            ie_q    <= wr_data[29];
            op_q    <= wr_op;
            phy_q   <= wr_data[25:21];
            ra_q    <= wr_data[20:16];
            dat_q   <= wr_data[15:0];
            ready_q <= 1'b0;
            irq_q   <= 1'b0;
            noop_q  <= !op_valid;
        end else if (noop_q) begin
            ready_q <= 1'b1;
            noop_q  <= 1'b0;
        end else if (done) begin
            ready_q <= 1'b1;
            irq_q   <= ie_q;
            if (op_q == OP_READ) dat_q <= rdata;
        end
    end

    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ready_q && !done && !noop_q) |=> (rd_data == $past(rd_data)));

    a_r8_irq_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ready_q);

    a_r10_noop_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        noop_q |=> ready_q && !irq_q);

endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: mdio_mgmt_master (top)
// Ties the command register, the frame sequencer and the clock divider.
// Assumes: the board pulls the data line high; mdio_o is only meaningful
// while mdio_oe is 1.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int HALF_PERIOD = 4,
    parameter int PRE_LEN     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        start, active, done, rise_tick, fall_tick;
    mdio_op_e    op;
    logic [4:0]  phy_addr, reg_addr;
    logic [15:0] data, rdata;

    mdio_cmd_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done(done), .rdata(rdata), .start(start), .op(op),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .data(data),
        .rd_data(rd_data), .irq(irq)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(data),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .active(active), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rdata(rdata)
    );

    mdc_divider #(.HALF_PERIOD(HALF_PERIOD)) u_div (
        .clk(clk), .rst_n(rst_n), .en(active),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    a_r2_mdc_low_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[28] |-> !mdc);

    a_r11_released_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[28] |-> !mdio_oe);

    a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int HALF = 4;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    mdio_mgmt_master #(.HALF_PERIOD(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // Bench-side cycle counter, advanced away from the active edge.
    int cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;

    // Line monitor and PHY model.
    logic        cap [0:79];
    logic        cap_oe [0:79];
    int          nrise = 0;
    int          last_rise = 0;
    int          per_err = 0;
    logic [15:0] phy_val = 16'h0000;

    always @(posedge mdc) begin
        if (nrise < 80) begin
            cap[nrise]    = mdio_oe ? mdio_o : mdio_i;
            cap_oe[nrise] = mdio_oe;
        end
        if (nrise > 0 && (cyc - last_rise) != 2 * HALF) per_err++;
        last_rise = cyc;
        nrise++;
    end

    always @(negedge mdc) begin
        if (nrise >= 48 && nrise < 64) mdio_i = phy_val[63 - nrise];
        else                           mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic ie, input logic [1:0] op,
                                       input logic [4:0] phy, input logic [4:0] ra,
                                       input logic [15:0] d);
        return {2'b11, ie, 1'b0, op, phy, ra, d};
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue a command and wait for ready; returns cycles from accept.
    task automatic run_cmd(input logic [31:0] w, output int n);
        nrise = 0;
        per_err = 0;
        wr(w);
        n = 0;
        while (!rd_data[28]) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reg", rd_data, 32'h1000_0000);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 mdc", {31'd0, mdc}, 32'd0);
        check("R11 oe at reset", {31'd0, mdio_oe}, 32'd0);
    endtask

    task automatic t_write(input logic ie, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] d);
        int n;
        int errs = 0;
        int oe_errs = 0;
        logic [31:0] pay;
        pay = {2'b01, 2'b01, phy, ra, 2'b10, d};
        run_cmd(mk(ie, 2'b01, phy, ra, d), n);
        check("R2 frame cycles", n, FRAME_CYC);
        check("R2 rise count", nrise, 64);
        check("R2 period", per_err, 0);
        for (int k = 0; k < 64; k++) begin
            if (cap[k] !== ((k < 32) ? 1'b1 : pay[63 - k])) errs++;
            if (cap_oe[k] !== 1'b1) oe_errs++;
        end
        check("R3 write bits", errs, 0);
        check("R3 write drive", oe_errs, 0);
        check("R7 readback", rd_data, {2'b00, ie, 1'b1, 2'b01, phy, ra, d});
        check("R8 irq follows ie", {31'd0, irq}, {31'd0, ie});
        check("R11 oe after frame", {31'd0, mdio_oe}, 32'd0);
    endtask

    task automatic t_read(input logic ie, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] v);
        int n;
        int errs = 0;
        int oe_errs = 0;
        logic [13:0] hdr;
        hdr = {2'b01, 2'b10, phy, ra};
        phy_val = v;
        run_cmd(mk(ie, 2'b10, phy, ra, 16'h1234), n);
        for (int k = 0; k < 46; k++) begin
            if (cap[k] !== ((k < 32) ? 1'b1 : hdr[45 - k])) errs++;
        end
        for (int k = 0; k < 64; k++) begin
            if (cap_oe[k] !== ((k < 46) ? 1'b1 : 1'b0)) oe_errs++;
        end
        check("R5 read header", errs, 0);
        check("R5 release profile", oe_errs, 0);
        check("R6 read data", rd_data, {2'b00, ie, 1'b1, 2'b10, phy, ra, v});
        check("R2 read cycles", n, FRAME_CYC);
    endtask

    task automatic t_irq_hold();
        int n;
        run_cmd(mk(1'b1, 2'b01, 5'd3, 5'd9, 16'h0F0F), n);
        repeat (10) @(negedge clk);
        check("R8 irq held", {31'd0, irq}, 32'd1);
        wr(mk(1'b0, 2'b10, 5'd3, 5'd9, 16'h0));
        check("R8 irq cleared by write", {31'd0, irq}, 32'd0);
        while (!rd_data[28]) @(negedge clk);
        check("R8 irq stays low without ie", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_busy();
        int errs = 0;
        logic [31:0] pay;
        pay = {2'b01, 2'b01, 5'd7, 5'd2, 2'b10, 16'hC0DE};
        nrise = 0;
        wr(mk(1'b0, 2'b01, 5'd7, 5'd2, 16'hC0DE));
        repeat (100) @(negedge clk);
        wr(mk(1'b1, 2'b10, 5'd30, 5'd30, 16'hFFFF));
        check("R9 busy write ignored", rd_data, {2'b00, 1'b0, 1'b0, 2'b01, 5'd7, 5'd2, 16'hC0DE});
        while (!rd_data[28]) @(negedge clk);
        for (int k = 0; k < 64; k++)
            if (cap[k] !== ((k < 32) ? 1'b1 : pay[63 - k])) errs++;
        check("R9 frame unchanged", errs, 0);
        check("R9 rise count", nrise, 64);
        check("R9 final reg", rd_data, {2'b00, 1'b0, 1'b1, 2'b01, 5'd7, 5'd2, 16'hC0DE});
    endtask

    task automatic t_rsvd(input logic [1:0] op);
        nrise = 0;
        wr(mk(1'b1, op, 5'd1, 5'd1, 16'hAAAA));
        check("R10 ready low one cycle", {31'd0, rd_data[28]}, 32'd0);
        @(negedge clk);
        check("R10 ready back", rd_data, {2'b00, 1'b1, 1'b1, op, 5'd1, 5'd1, 16'hAAAA});
        repeat (40) @(negedge clk);
        check("R10 no mdc", nrise, 0);
        check("R10 no irq", {31'd0, irq}, 32'd0);
        check("R11 no drive", {31'd0, mdio_oe}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_write(1'b0, 5'd1, 5'd0, 16'hFFFF);
                t_write(1'b1, 5'd31, 5'd17, 16'h0000);
                t_write(1'b0, 5'd10, 5'd21, 16'hA5A5);
                t_read(1'b0, 5'd5, 5'd1, 16'hA5C3);
                t_read(1'b1, 5'd18, 5'd31, 16'h8001);
                t_irq_hold();
                t_busy();
                t_rsvd(2'b00);
                t_rsvd(2'b11);
            end
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule